// File: doc/BRIEF.md
# Multiframe Clock Timing Generator

This block produces the frame and multiframe timing for one end of a multi-lane serial converter link. It runs on the octet clock. A frame is a run of F octet-clock cycles, and a multiframe is K frames, so a multiframe lasts F times K cycles. The block marks the first octet of every frame with a frame strobe. It marks the first octet of every multiframe with a multiframe strobe. Buffered receive data is released to the application on these multiframe boundaries, which gives the link a latency that repeats from one power-up to the next. F and K are runtime inputs and may be changed only while reset is held.

In the timing mode that uses an external reference, a reference pulse input sets the phase of the multiframe counter. The pulse is brought into the clock domain through two flops, and only a rising edge counts as an event. In periodic interpretation, the pulse train may run continuously or with gaps. An edge that agrees with the running phase leaves the counters alone. An edge that disagrees re-phases them and sets a sticky misalignment flag. In one-shot interpretation, only the first edge after reset or after re-arming has any effect. In the free-running timing mode the reference input is ignored entirely.

Top module: `lmfc_timing_gen`

## Requirements
- R1: `frameStart` is high on the first cycle of every frame and low on the other F-1 cycles, for any F from 1 to MAX_F.
- R2: `lmfcStart` is high once every F*K cycles, on a cycle where `frameStart` is also high, for any K from 1 to 32.
- R3: After reset is released, both strobes are high in the first cycle, and `sysrefCaptured` and `misaligned` are 0.
- R4: With `subclass1` = 0, `sysref` has no effect: the strobes keep the free-running pattern and both flags stay 0.
- R5: `sysref` is sampled on the clock edge, passes through two flops, and is acted on only at a 0-to-1 change. An accepted edge whose sample is first seen high at clock edge n makes `lmfcStart` high in the cycle after edge n+2. While `sysref` stays high, no further event occurs.
- R6: With `subclass1` = 1 and `oneShot` = 0, the first edge after reset or arm re-phases the counters. It sets `sysrefCaptured` to 1 and leaves `misaligned` at 0.
- R7: In periodic mode (`oneShot` = 0), once captured, an edge that arrives in the last cycle of a multiframe changes no phase and sets no flag. Gaps in the pulse train cause no action.
- R8: In periodic mode, once captured, an edge in any other cycle re-phases the counters as in R5 and sets `misaligned` to 1. `misaligned` stays 1 until arm or reset.
- R9: With `oneShot` = 1, after the first accepted edge, later edges change neither the phase nor either flag.
- R10: A one-cycle `arm` pulse clears `sysrefCaptured` and `misaligned` on the next cycle and re-enables one-shot capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rstN | input | 1 | Synchronous active-low reset |
| subclass1 | input | 1 | 1 = reference-aligned timing, 0 = free-running |
| oneShot | input | 1 | 1 = one-shot interpretation, 0 = periodic (continuous or gapped) |
| arm | input | 1 | Clears the status flags and re-arms one-shot capture |
| sysref | input | 1 | External phase reference pulse |
| octetsPerFrame | input | FW | F, from 1 to MAX_F |
| framesPerMf | input | KW | K, from 1 to MAX_K |
| frameStart | output | 1 | First octet of a frame |
| lmfcStart | output | 1 | First octet of a multiframe |
| sysrefCaptured | output | 1 | A reference edge has been accepted since reset or arm |
| misaligned | output | 1 | Sticky: a periodic edge disagreed with the running phase |

## Verification
The free-running counters are swept over a grid of F and K values that includes F = 1, F = MAX_F, K = 1 and K = 32. This grid separates a correct wrap from an off-by-one in either counter. During the sweep, `sysref` is toggled with the reference mode off, which shows that the input is really ignored. Periodic pulse trains are tried three ways: spaced exactly one multiframe apart, with a missing pulse, and with one pulse shifted. These tell the no-change path apart from re-phasing and from the sticky flag. A one-shot run with a late off-phase pulse, followed by arm and a fresh pulse, separates ignored edges from re-armed capture. Each pulse is held high for several cycles, so a design that reacts to the level instead of the edge is caught.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;
  typedef struct packed {
    logic realign;
    logic flagMisalign;
  } lmfcStrobes_t;
endpackage

// File: rtl/lmfc_ctrl.sv
module lmfc_ctrl
  import lmfc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         subclass1,
  input  logic         oneShot,
  input  logic         arm,
  input  logic         sysref,
  input  logic         mfLast,
  output lmfcStrobes_t strobes,
  output logic         captured,
  output logic         misaligned
);
  logic [1:0] syncQ;
  logic       sysPrev;
  logic       sysEdge;
  logic       accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      sysPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], sysref};
      sysPrev <= syncQ[1];
    end
  end

  always_comb begin
    sysEdge = syncQ[1] & ~sysPrev;
    accept  = subclass1 && sysEdge && (!oneShot || !captured);
    strobes.realign      = accept && (oneShot || !captured || !mfLast);
    strobes.flagMisalign = accept && !oneShot && captured && !mfLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      captured   <= 1'b0;
      misaligned <= 1'b0;
    end else begin
      if (accept)   captured <= 1'b1;
      else if (arm) captured <= 1'b0;
      if (strobes.flagMisalign) misaligned <= 1'b1;
      else if (arm)             misaligned <= 1'b0;
    end
  end

  AST_SC0_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !subclass1 |-> !strobes.realign && !strobes.flagMisalign); // R4
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    oneShot && captured |-> !strobes.realign); // R9
  AST_MIS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    misaligned && !arm |=> misaligned); // R8
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    arm && !accept |=> !captured && !misaligned); // R10
endmodule

// File: rtl/lmfc_datapath.sv
module lmfc_datapath
  import lmfc_pkg::*;
#(
  parameter int FW = 5,
  parameter int KW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [FW-1:0] octetsPerFrame,
  input  logic [KW-1:0] framesPerMf,
  input  lmfcStrobes_t  strobes,
  output logic          mfLast,
  output logic          frameStart,
  output logic          lmfcStart
);
  logic [FW-1:0] octetCnt;
  logic [KW-1:0] frameCnt;
  logic          frameLast;

  always_comb begin
    frameLast  = (octetCnt == octetsPerFrame - FW'(1));
    mfLast     = frameLast && (frameCnt == framesPerMf - KW'(1));
    frameStart = (octetCnt == '0);
    lmfcStart  = frameStart && (frameCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.realign) begin
      octetCnt <= '0;
      frameCnt <= '0;
    end else if (frameLast) begin
      octetCnt <= '0;
      frameCnt <= mfLast ? '0 : frameCnt + KW'(1);
    end else begin
      octetCnt <= octetCnt + FW'(1);
    end
  end

  AST_OCTET_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    octetCnt < octetsPerFrame); // R1
  AST_OCTET_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.realign && !frameLast |=> octetCnt == $past(octetCnt) + FW'(1)); // R1
  AST_MF_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    mfLast |=> lmfcStart); // R2
  AST_REALIGN_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.realign |=> lmfcStart); // R5
endmodule

// File: rtl/lmfc_timing_gen.sv
module lmfc_timing_gen
  import lmfc_pkg::*;
#(
  parameter int MAX_F = 16,
  parameter int MAX_K = 32,
  localparam int FW = $clog2(MAX_F + 1),
  localparam int KW = $clog2(MAX_K + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          subclass1,
  input  logic          oneShot,
  input  logic          arm,
  input  logic          sysref,
  input  logic [FW-1:0] octetsPerFrame,
  input  logic [KW-1:0] framesPerMf,
  output logic          frameStart,
  output logic          lmfcStart,
  output logic          sysrefCaptured,
  output logic          misaligned
);
  lmfcStrobes_t strobes;
  logic         mfLast;

  lmfc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .subclass1(subclass1), .oneShot(oneShot),
    .arm(arm), .sysref(sysref), .mfLast(mfLast), .strobes(strobes),
    .captured(sysrefCaptured), .misaligned(misaligned)
  );

  lmfc_datapath #(.FW(FW), .KW(KW)) u_dp (
    .clk(clk), .rstN(rstN), .octetsPerFrame(octetsPerFrame),
    .framesPerMf(framesPerMf), .strobes(strobes), .mfLast(mfLast),
    .frameStart(frameStart), .lmfcStart(lmfcStart)
  );
endmodule

// File: tb/sim_lmfc_timing_gen.sv
module sim_lmfc_timing_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       subclass1 = 1'b0;
  logic       oneShot = 1'b0;
  logic       arm = 1'b0;
  logic       sysref = 1'b0;
  logic [4:0] octetsPerFrame = 5'd1;
  logic [5:0] framesPerMf = 6'd1;
  logic       frameStart, lmfcStart, sysrefCaptured, misaligned;

  int checks = 0;
  int fails = 0;
  int mF, mK, phase;
  logic m1, m2, m3, mCapt, mMis;
  string flagTag = "R3";

  always #10 clk = ~clk;

  lmfc_timing_gen u0 (
    .clk(clk), .rstN(rstN), .subclass1(subclass1), .oneShot(oneShot),
    .arm(arm), .sysref(sysref), .octetsPerFrame(octetsPerFrame),
    .framesPerMf(framesPerMf), .frameStart(frameStart), .lmfcStart(lmfcStart),
    .sysrefCaptured(sysrefCaptured), .misaligned(misaligned)
  );

  task automatic cmp(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (F=%0d K=%0d phase=%0d)",
               req, act, exp, mF, mK, phase);
    end
  endtask

  task automatic checkAll();
    cmp("R1 frameStart", frameStart, (phase % mF) == 0);
    cmp("R2 lmfcStart", lmfcStart, phase == 0);
    cmp({flagTag, " sysrefCaptured"}, sysrefCaptured, mCapt);
    cmp({flagTag, " misaligned"}, misaligned, mMis);
  endtask

  task automatic doReset(int f, int k);
    rstN = 1'b0; sysref = 1'b0; arm = 1'b0;
    octetsPerFrame = 5'(f); framesPerMf = 6'(k);
    mF = f; mK = k;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    phase = 0; m1 = 0; m2 = 0; m3 = 0; mCapt = 0; mMis = 0;
    flagTag = "R3";
    checkAll();
  endtask

  task automatic tick();
    logic s, a, edgeM, accept, realign, flagM;
    s = sysref; a = arm;
    @(posedge clk);
    @(negedge clk);
    edgeM   = m2 & ~m3;
    accept  = subclass1 && edgeM && (!oneShot || !mCapt);
    realign = accept && (oneShot || !mCapt || phase != mF * mK - 1);
    flagM   = accept && !oneShot && mCapt && phase != mF * mK - 1;
    phase   = realign ? 0 : (phase + 1) % (mF * mK);
    if (accept) mCapt = 1; else if (a) mCapt = 0;
    if (flagM) mMis = 1; else if (a) mMis = 0;
    m3 = m2; m2 = m1; m1 = s;
    checkAll();
  endtask

  task automatic pulse(int high, int low);
    sysref = 1'b1;
    repeat (high) tick();
    sysref = 1'b0;
    repeat (low) tick();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int fv[4] = '{1, 2, 3, 16};
    int kv[4] = '{1, 2, 3, 32};
    // R1 R2 R4: free-running sweep with sysref toggling but ignored
    subclass1 = 1'b0;
    foreach (fv[i]) begin
      foreach (kv[j]) begin
        doReset(fv[i], kv[j]);
        flagTag = "R4";
        for (int c = 0; c < 2 * fv[i] * kv[j] + 4; c++) begin
          sysref = ((c % 7) < 3);
          tick();
        end
      end
    end

    // Periodic interpretation, F=3 K=4
    subclass1 = 1'b1; oneShot = 1'b0;
    doReset(3, 4);
    repeat (5) tick();
    flagTag = "R6";
    sysref = 1'b1;
    repeat (3) tick();
    cmp("R5 boundary three edges after rise", lmfcStart, 1'b1);
    tick();
    cmp("R5 level held high no retrigger", lmfcStart, 1'b0);
    cmp("R6 captured", sysrefCaptured, 1'b1);
    cmp("R6 no misalign on first edge", misaligned, 1'b0);
    sysref = 1'b0;
    repeat (12 - 4) tick();
    flagTag = "R7";
    repeat (3) pulse(2, 10);
    pulse(2, 22);   // gap of a whole multiframe
    pulse(2, 10);
    cmp("R7 aligned edges leave flag low", misaligned, 1'b0);
    flagTag = "R8";
    repeat (5) tick();
    pulse(3, 12);
    cmp("R8 shifted edge sets misaligned", misaligned, 1'b1);
    repeat (20) tick();
    cmp("R8 misaligned sticky", misaligned, 1'b1);
    flagTag = "R10";
    arm = 1'b1; tick(); arm = 1'b0;
    cmp("R10 arm clears misaligned", misaligned, 1'b0);
    cmp("R10 arm clears captured", sysrefCaptured, 1'b0);
    repeat (4) tick();

    // One-shot interpretation, F=2 K=3
    oneShot = 1'b1;
    doReset(2, 3);
    flagTag = "R9";
    repeat (4) tick();
    pulse(2, 9);
    cmp("R9 first edge captured", sysrefCaptured, 1'b1);
    pulse(2, 9);
    pulse(4, 7);
    cmp("R9 later edges leave misaligned low", misaligned, 1'b0);
    flagTag = "R10";
    arm = 1'b1; tick(); arm = 1'b0;
    cmp("R10 re-armed", sysrefCaptured, 1'b0);
    tick();
    sysref = 1'b1;
    repeat (3) tick();
    cmp("R10 re-armed edge realigns", lmfcStart, 1'b1);
    sysref = 1'b0;
    repeat (8) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule